// File: doc/BRIEF.md
# Synchronous burst late-write SRAM

This block is a clocked single-port static memory with a registered command interface. On every rising clock edge it samples a command and classifies it as one of five kinds. A load with the chip selected starts a read or a write at a fresh external address. A continue repeats the previous kind of operation at the next burst address. The two deselects put the data bus into high impedance. A bank deselect also turns off the echo-clock enable, and a plain deselect leaves it on.

The data word is 72 bits wide and is split into eight byte lanes of nine bits. Writes are late: the data for a write command sampled at one edge is taken from `dq_in` at the following edge. Each lane has its own active-low write strobe, and a beat whose strobes are all high is an aborted write. A read drives its word during the cycle after its command edge. It returns pending late-write data when the previous edge wrote the same address.

A burst holds four beats. The low two address bits count modulo 4 and the upper bits stay fixed, so a fourth continue returns to the loaded base address. The controller is a four-state machine: BANK_OFF (after reset or a bank deselect), DESEL (after a deselect), READ and WRITE. From any state, a load with `chip_sel_n` high goes to BANK_OFF. A load with the chip selected but the enables not matching the straps goes to DESEL. A matching load goes to READ or WRITE depending on `wr_n`. A continue keeps the current state, and in READ or WRITE it advances the burst address.

Top module: `burst_sram`

## Requirements
- R1: While `rst_n` is low and after its release, before any command, `dq_oe` and `echo_oe` are both 0.
- R2: A load (`load_n`=0) with `chip_sel_n`=1 is a bank deselect: in the next cycle `dq_oe`=0 and `echo_oe`=0.
- R3: A load with `chip_sel_n`=0 where `en2`≠`strap2` or `en3`≠`strap3` is a deselect: in the next cycle `dq_oe`=0 and `echo_oe`=1.
- R4: A load with `chip_sel_n`=0, matching enables and `wr_n`=1 reads the word at `addr`: in the next cycle `dq_oe`=1 and `dq_out` holds that word.
- R5: A matching load with `wr_n`=0 is a write. The data comes from `dq_in` at the following clock edge, and in the cycle after the command `dq_oe`=0 and `echo_oe`=1.
- R6: On a write beat, lane i (bits i*9+8 down to i*9) is stored only when `lane_wr_n[i]`=0. Lanes whose strobe is high keep their old content.
- R7: A write beat with all `lane_wr_n` high stores nothing, but the burst address still loads or advances.
- R8: A continue (`load_n`=1) in READ or WRITE adds 1 modulo 4 to the low two address bits and keeps the upper bits. A fourth continue returns to the base address.
- R9: A continue repeats the previous operation kind and ignores `chip_sel_n`, `en2` and `en3`. After a deselect or bank deselect it keeps the same bus state.
- R10: A read whose address equals the write beat of the previous edge returns, for each lane that beat enables, the `dq_in` value sampled at the read's edge.
- R11: `echo_oe` falls only in the cycle after a bank deselect. It stays 1 after reads, writes and plain deselects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_n | input | 1 | Low: new operation with external address; high: continue |
| chip_sel_n | input | 1 | Active-low chip select |
| en2 | input | 1 | Enable compared with `strap2` |
| en3 | input | 1 | Enable compared with `strap3` |
| strap2 | input | 1 | Level `en2` must match |
| strap3 | input | 1 | Level `en3` must match |
| wr_n | input | 1 | Low: write, high: read (on a load) |
| lane_wr_n | input | LANES (8) | Active-low per-lane write strobes |
| addr | input | ADDR_W (6) | External word address |
| dq_in | input | DATA_W (72) | Write data, taken one edge after the write command |
| dq_out | output | DATA_W (72) | Read data |
| dq_oe | output | 1 | Data bus drive enable |
| echo_oe | output | 1 | Echo-clock drive enable |

## Verification
The bench builds the block with a 5-bit address (32 words) and the default eight 9-bit lanes. With so few words, random traffic often revisits addresses, reads right behind writes to the same word (the bypass path), and runs bursts over the wrap of the low two bits. Strobe patterns are biased toward all-high and all-low so that aborted and full writes occur often next to partial-lane writes. Random continues after deselects, and random select inputs during continues, exercise the state-holding rules.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    // Last accepted operation kind; a continue re-uses it
    typedef enum logic [1:0] {
        ST_BANK_OFF = 2'd0,
        ST_DESEL    = 2'd1,
        ST_READ     = 2'd2,
        ST_WRITE    = 2'd3
    } op_state_t;

    localparam int BURST_BITS = 2;

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              chip_sel_n,
    input  logic              en2,
    input  logic              en3,
    input  logic              strap2,
    input  logic              strap3,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              rd_go,
    output logic              wr_go,
    output logic [LANES-1:0]  wr_lanes,
    output logic              dq_oe,
    output logic              echo_oe,
    output op_state_t         state_q
);

    localparam int HI_W = ADDR_W - BURST_BITS;

    op_state_t             state_d;
    logic                  match;
    logic                  is_access;
    logic [ADDR_W-1:0]     base_q;
    logic [BURST_BITS-1:0] cnt_q;
    logic [BURST_BITS-1:0] next_lo;
    logic [HI_W-1:0]       base_hi;

    assign match   = (en2 == strap2) && (en3 == strap3);
    assign base_hi = base_q[ADDR_W-1:BURST_BITS];
    assign next_lo = base_q[BURST_BITS-1:0] + cnt_q + 2'd1;

    // Next-state decode
    always_comb begin
        state_d = state_q;
        if (!load_n) begin
            if (chip_sel_n)   state_d = ST_BANK_OFF;
            else if (!match)  state_d = ST_DESEL;
            else if (wr_n)    state_d = ST_READ;
            else              state_d = ST_WRITE;
        end
    end

    // Access strobes for this edge
    always_comb begin
        rd_go = 1'b0;
        wr_go = 1'b0;
        unique case (state_d)
            ST_BANK_OFF: ;
            ST_DESEL:    ;
            ST_READ:     rd_go = 1'b1;
            ST_WRITE:    wr_go = 1'b1;
        endcase
    end

    assign is_access = rd_go || wr_go;
    assign acc_addr  = (!load_n) ? addr : {base_hi, next_lo};
    assign wr_lanes  = wr_go ? ~lane_wr_n : '0;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BANK_OFF;
        else        state_q <= state_d;
    end

    // Burst address register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (is_access) begin
            if (!load_n) begin
                base_q <= addr;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_q + 2'd1;
            end
        end
    end

    // Bus enables, one cycle after the command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_oe   <= 1'b0;
            echo_oe <= 1'b0;
        end else begin
            unique case (state_d)
                ST_BANK_OFF: begin dq_oe <= 1'b0; echo_oe <= 1'b0; end
                ST_DESEL:    begin dq_oe <= 1'b0; echo_oe <= 1'b1; end
                ST_READ:     begin dq_oe <= 1'b1; echo_oe <= 1'b1; end
                ST_WRITE:    begin dq_oe <= 1'b0; echo_oe <= 1'b1; end
            endcase
        end
    end

endmodule

// File: rtl/burst_sram_lane.sv
module burst_sram_lane #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              bypass,
    output logic [LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= bypass ? wr_data : mem[rd_addr];
    end

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 8,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_go,
    input  logic                    rd_go,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out
);

    logic              pend_v;
    logic [ADDR_W-1:0] pend_addr;
    logic [LANES-1:0]  pend_lanes;
    logic              same_addr;

    // Late-write holding register: address and lanes wait one edge for data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v     <= 1'b0;
            pend_addr  <= '0;
            pend_lanes <= '0;
        end else begin
            pend_v     <= wr_go;
            pend_addr  <= acc_addr;
            pend_lanes <= wr_lanes;
        end
    end

    assign same_addr = pend_v && (pend_addr == acc_addr);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        burst_sram_lane #(
            .ADDR_W (ADDR_W),
            .LANE_W (LANE_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (pend_v && pend_lanes[i]),
            .wr_addr (pend_addr),
            .wr_data (dq_in[i*LANE_W +: LANE_W]),
            .rd_en   (rd_go),
            .rd_addr (acc_addr),
            .bypass  (same_addr && pend_lanes[i]),
            .rd_data (dq_out[i*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 8,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              chip_sel_n,
    input  logic              en2,
    input  logic              en3,
    input  logic              strap2,
    input  logic              strap3,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              echo_oe
);

    logic [ADDR_W-1:0] acc_addr;
    logic              rd_go;
    logic              wr_go;
    logic [LANES-1:0]  wr_lanes;
    op_state_t         state_q;

    burst_sram_ctrl #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_n     (load_n),
        .chip_sel_n (chip_sel_n),
        .en2        (en2),
        .en3        (en3),
        .strap2     (strap2),
        .strap3     (strap3),
        .wr_n       (wr_n),
        .lane_wr_n  (lane_wr_n),
        .addr       (addr),
        .acc_addr   (acc_addr),
        .rd_go      (rd_go),
        .wr_go      (wr_go),
        .wr_lanes   (wr_lanes),
        .dq_oe      (dq_oe),
        .echo_oe    (echo_oe),
        .state_q    (state_q)
    );

    burst_sram_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_go    (wr_go),
        .rd_go    (rd_go),
        .acc_addr (acc_addr),
        .wr_lanes (wr_lanes),
        .dq_in    (dq_in),
        .dq_out   (dq_out)
    );

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_n,
    input logic              chip_sel_n,
    input logic              en2,
    input logic              en3,
    input logic              strap2,
    input logic              strap3,
    input logic              wr_n,
    input logic              dq_oe,
    input logic              echo_oe,
    input logic [ADDR_W-1:0] acc_addr,
    input op_state_t         state_q
);

    logic sel_ok;
    assign sel_ok = !chip_sel_n && (en2 == strap2) && (en3 == strap3);

    // R2
    bank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && chip_sel_n) |=> (!dq_oe && !echo_oe));

    // R3
    desel_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !chip_sel_n && !sel_ok) |=> (!dq_oe && echo_oe));

    // R4
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && sel_ok && wr_n) |=> dq_oe);

    // R5
    write_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && sel_ok && !wr_n) |=> (!dq_oe && echo_oe));

    // R8
    burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && (state_q == ST_READ || state_q == ST_WRITE)) |->
        (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2]) &&
         acc_addr[1:0] == 2'($past(acc_addr[1:0]) + 2'd1)));

    // R9
    cont_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && (state_q == ST_DESEL || state_q == ST_BANK_OFF)) |=>
        (!dq_oe && $stable(echo_oe)));

    // R11
    echo_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(echo_oe) |-> $past(!load_n && chip_sel_n));

endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_n     (load_n),
    .chip_sel_n (chip_sel_n),
    .en2        (en2),
    .en3        (en3),
    .strap2     (strap2),
    .strap3     (strap3),
    .wr_n       (wr_n),
    .dq_oe      (dq_oe),
    .echo_oe    (echo_oe),
    .acc_addr   (acc_addr),
    .state_q    (state_q)
);

// File: tb/burst_sram_bench.sv
module burst_sram_bench;

    localparam int ADDR_W = 5;
    localparam int LANES  = 8;
    localparam int LANE_W = 9;
    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int M_BANK = 0, M_DES = 1, M_RD = 2, M_WR = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_n = 1'b1, chip_sel_n = 1'b1, en2 = 1'b1, en3 = 1'b0;
    logic              strap2 = 1'b1, strap3 = 1'b0;
    logic              wr_n = 1'b1;
    logic [LANES-1:0]  lane_wr_n = '1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] dq_in = '0;
    logic [DATA_W-1:0] dq_out;
    logic              dq_oe, echo_oe;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    burst_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_burst_sram (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .chip_sel_n(chip_sel_n),
        .en2(en2), .en3(en3), .strap2(strap2), .strap3(strap3), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .echo_oe(echo_oe)
    );

    // Reference model state
    logic [LANE_W-1:0] ref_mem [DEPTH][LANES];
    bit                known   [DEPTH][LANES];
    int                m_st = M_BANK;
    logic [ADDR_W-1:0] m_base = '0;
    logic [1:0]        m_cnt = '0;
    bit                p_v = 0;
    logic [ADDR_W-1:0] p_addr = '0;
    logic [LANES-1:0]  p_lanes = '0;
    logic [DATA_W-1:0] e_data = '0;
    logic [DATA_W-1:0] e_known = '0;

    function automatic logic [DATA_W-1:0] rnd_word();
        return DATA_W'({$urandom(), $urandom(), $urandom()});
    endfunction

    function automatic logic [ADDR_W-1:0] burst_addr(logic [ADDR_W-1:0] b, logic [1:0] c);
        return {b[ADDR_W-1:2], 2'(b[1:0] + c)};
    endfunction

    task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply the rules at one rising edge
    task automatic model_edge();
        logic [ADDR_W-1:0] a;
        bit acc = 0;
        if (p_v) begin
            for (int i = 0; i < LANES; i++)
                if (p_lanes[i]) begin
                    ref_mem[p_addr][i] = dq_in[i*LANE_W +: LANE_W];
                    known[p_addr][i]   = 1;
                end
        end
        p_v = 0;
        a = '0;
        if (!load_n) begin
            if (chip_sel_n)                              m_st = M_BANK;
            else if (en2 != strap2 || en3 != strap3)     m_st = M_DES;
            else                                         m_st = wr_n ? M_RD : M_WR;
            if (m_st == M_RD || m_st == M_WR) begin
                m_base = addr; m_cnt = 2'd0; a = addr; acc = 1;
            end
        end else if (m_st == M_RD || m_st == M_WR) begin
            m_cnt = m_cnt + 2'd1;
            a = burst_addr(m_base, m_cnt);
            acc = 1;
        end
        if (acc && m_st == M_WR) begin
            p_v = 1; p_addr = a; p_lanes = ~lane_wr_n;
        end
        if (acc && m_st == M_RD) begin
            for (int i = 0; i < LANES; i++) begin
                e_data[i*LANE_W +: LANE_W]  = ref_mem[a][i];
                e_known[i*LANE_W +: LANE_W] = known[a][i] ? '1 : '0;
            end
        end
    endtask

    task automatic run_cycle(logic ld, logic cs, logic e2, logic e3, logic w,
                             logic [LANES-1:0] bw, logic [ADDR_W-1:0] a, string tag);
        string t;
        load_n = ld; chip_sel_n = cs; en2 = e2; en3 = e3; wr_n = w;
        lane_wr_n = bw; addr = a; dq_in = rnd_word();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        t = tag;
        if (t == "") begin
            case (m_st)
                M_RD:    t = "R4";
                M_WR:    t = "R5";
                M_DES:   t = "R3";
                default: t = "R2";
            endcase
        end
        chk({t, " dq_oe"}, DATA_W'(dq_oe), DATA_W'(m_st == M_RD));
        chk({t, " echo_oe R11"}, DATA_W'(echo_oe), DATA_W'(m_st != M_BANK));
        if (m_st == M_RD && e_known != '0)
            chk({t, " dq_out"}, dq_out & e_known, e_data & e_known);
    endtask

    task automatic do_read(logic [ADDR_W-1:0] a, string tag);
        run_cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, '1, a, tag);
    endtask
    task automatic do_write(logic [ADDR_W-1:0] a, logic [LANES-1:0] bw, string tag);
        run_cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, bw, a, tag);
    endtask
    task automatic do_cont(logic [LANES-1:0] bw, string tag);
        // select inputs deliberately scrambled: a continue must ignore them
        run_cycle(1'b1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  bw, ADDR_W'($urandom), tag);
    endtask
    task automatic do_bank(string tag);
        run_cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, '1, '0, tag);
    endtask
    task automatic do_desel(string tag);
        run_cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '1, '0, tag);
    endtask

    // Watchdog
    initial begin
        #(10 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int d = 0; d < DEPTH; d++)
            for (int i = 0; i < LANES; i++) begin
                ref_mem[d][i] = '0; known[d][i] = 0;
            end

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 dq_oe in reset", DATA_W'(dq_oe), '0);
        chk("R1 echo_oe in reset", DATA_W'(echo_oe), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 dq_oe after reset", DATA_W'(dq_oe), '0);
        chk("R1 echo_oe after reset", DATA_W'(echo_oe), '0);

        // R2, R9: bank deselect and a continue after it
        do_bank("R2");
        do_cont('1, "R9 bank");

        // R8: write burst of five beats from base 6 (wraps onto 6 again)
        do_write(5'd6, '0, "R8 wr");
        repeat (4) do_cont('0, "R8 wr");
        do_desel("R3");
        do_read(5'd6, "R8 rd");
        repeat (4) do_cont('1, "R8 rd");

        // R7: aborted beat leaves old data, burst still advances to 10
        do_write(5'd9, '0, "R7 prep");
        do_write(5'd9, '1, "R7 abort");
        do_cont('0, "R7 step");
        do_read(5'd9, "R7 rd");
        do_cont('1, "R7 rd next");

        // R6: only lanes 0..3 written
        do_write(5'd12, '0, "R6 prep");
        do_write(5'd12, 8'hF0, "R6 partial");
        do_read(5'd12, "R6 rd");

        // R10: read right behind a write to the same word
        do_write(5'd20, 8'h0F, "R10 wr");
        do_read(5'd20, "R10 bypass");
        do_write(5'd21, '0, "R10 wr");
        do_read(5'd21, "R10 bypass");

        // R3, R9, R11: deselect keeps echo, continue keeps deselect
        do_desel("R3");
        do_cont('1, "R9 desel");
        do_read(5'd6, "R11 rd");

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [LANES-1:0] bw;
            int r;
            r = int'($urandom_range(0, 9));
            bw = (r < 2) ? '1 : (r < 4) ? '0 : LANES'($urandom);
            r = int'($urandom_range(0, 99));
            if (r < 35)      do_cont(bw, "");
            else if (r < 42) do_bank("");
            else if (r < 50) run_cycle(1'b0, 1'b0, 1'($urandom), ~strap3, 1'($urandom),
                                       bw, ADDR_W'($urandom), "");
            else             run_cycle(1'b0, 1'b0, strap2, strap3, 1'($urandom),
                                       bw, ADDR_W'($urandom), "");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule